// File: doc/BRIEF.md
# Gate driver fault supervisor

This block sits between a three-phase half-bridge gate controller and the gate outputs. It receives six gate commands, three high-side and three low-side, that an earlier stage has already made free of overlap. It also receives digital status bits from the power stage: an over-current trip, a low-side supply undervoltage flag, one high-side supply undervoltage flag per phase, and an enable. Each status bit passes through a two-flop synchronizer. The block then decides which commands may reach the gates, and it drives an active-low fault flag.

The protection sources follow different rules:
- **Trip and low-side undervoltage.** Either one removes all six gates and pulls the fault flag low. After the cause clears, a clear timer counts a programmable number of cycles. The fault flag releases and the gates return only when that count is reached.
- **Enable low.** After a glitch filter, enable low removes all six gates. It never touches the fault flag.
- **High-side undervoltage on a phase.** This removes only that phase's high-side gate. After the supply recovers, the gate comes back only on a fresh rising edge of its command.
- **Trip blanking.** A trip is ignored for a programmable blanking window after any gate turns on.

Out of reset, the fault flag is low and the gates are off until the first clear interval has run.

Top module: `gdrv_fault_sup`

## Requirements
- R1: While reset is active, and for CLR_CYC cycles after its release, fault_n is 0 and all six gates are 0. Then fault_n becomes 1, provided no cause is present.
- R2: An active trip, once synchronized and outside the blanking window, forces fault_n to 0 and all gates to 0. This happens two clock edges after the input rises.
- R3: After the synchronized trip clears, fault_n and the gates stay off for exactly CLR_CYC further edges. fault_n then returns to 1 and the gates follow their commands again.
- R4: Low-side undervoltage forces all gates off and fault_n to 0. It is not latched: after the flag drops, it releases through the same CLR_CYC clear interval.
- R5: High-side undervoltage on phase i forces hi_gate[i] to 0 and leaves fault_n and the other gates unchanged.
- R6: After the high-side supply of phase i recovers, hi_gate[i] stays 0 while hi_cmd[i] is held high. It turns on again only after hi_cmd[i] goes low and then rises.
- R7: Enable low, after filtering, forces all gates to 0 and leaves fault_n unchanged. It is not latched: the gates resume once enable has been high through the filter.
- R8: A low pulse on en_in shorter than EN_FILT_CYC cycles has no effect on the gates.
- R9: For BLANK_CYC cycles after any gate turns on, the trip input is ignored: fault_n stays 1 and the gates stay on. A trip still present afterwards takes effect.
- R10: The clear counter saturates. With no cause present, fault_n stays 1 however long the idle time lasts.
- R11: Whenever fault_n is 0, all gates are 0 regardless of enable. No gate is ever 1 while its command is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | N_PH | High-side gate commands, one per phase |
| lo_cmd | input | N_PH | Low-side gate commands, one per phase |
| trip_in | input | 1 | Over-current trip, active high, asynchronous |
| lsuv_in | input | 1 | Low-side supply undervoltage, active high, asynchronous |
| hsuv_in | input | N_PH | High-side supply undervoltage per phase, active high, asynchronous |
| en_in | input | 1 | Enable, active high, asynchronous |
| hi_gate | output | N_PH | Gated high-side outputs |
| lo_gate | output | N_PH | Gated low-side outputs |
| fault_n | output | 1 | Fault flag, active low |

## Verification
The assertions check the following on every cycle:
- no gate is on while the fault flag is low or while filtered enable is low;
- no gate is on without its command;
- a high-side gate is never on while its synchronized undervoltage flag is set;
- an unblanked trip or a low-side undervoltage always holds the fault flag low;
- the fault flag rises only after a cycle free of any cause;
- the clear counter never passes its limit.

Some behaviour can only be shown by the bench scenarios. These are the exact length of the clear interval and of the blanking window, the rejection of short enable pulses, and the need for a fresh command edge after high-side recovery. The bench also shows that enable and high-side undervoltage leave the fault flag alone.

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup #(
  parameter int N_PH        = 3,
  parameter int BLANK_CYC   = 100,
  parameter int EN_FILT_CYC = 50,
  parameter int CLR_CYC     = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PH-1:0] hi_cmd,
  input  logic [N_PH-1:0] lo_cmd,
  input  logic            trip_in,
  input  logic            lsuv_in,
  input  logic [N_PH-1:0] hsuv_in,
  input  logic            en_in,
  output logic [N_PH-1:0] hi_gate,
  output logic [N_PH-1:0] lo_gate,
  output logic            fault_n
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int FW = $clog2(EN_FILT_CYC + 1);
  localparam int CW = $clog2(CLR_CYC + 1);

  logic [1:0]      trip_sr, lsuv_sr, en_sr;
  logic [N_PH-1:0] hsuv_m, hsuv_s;
  logic            trip_s, lsuv_s, en_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trip_sr <= '0;
      lsuv_sr <= '0;
      en_sr   <= '0;
      hsuv_m  <= '0;
      hsuv_s  <= '0;
    end else begin
      trip_sr <= {trip_sr[0], trip_in};
      lsuv_sr <= {lsuv_sr[0], lsuv_in};
      en_sr   <= {en_sr[0], en_in};
      hsuv_m  <= hsuv_in;
      hsuv_s  <= hsuv_m;
    end

  assign trip_s = trip_sr[1];
  assign lsuv_s = lsuv_sr[1];
  assign en_s   = en_sr[1];

  logic          en_f;
  logic [FW-1:0] ef_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_f   <= 1'b0;
      ef_cnt <= '0;
    end else if (en_s == en_f) begin
      ef_cnt <= '0;
    end else if (ef_cnt == FW'(EN_FILT_CYC - 1)) begin
      en_f   <= en_s;
      ef_cnt <= '0;
    end else begin
      ef_cnt <= ef_cnt + 1'b1;
    end

  logic [BW-1:0]   blank_cnt;
  logic [CW-1:0]   clr_cnt;
  logic [N_PH-1:0] hi_q, lo_q, hcmd_q, arm, arm_now;
  logic            trip_eff, cause, clr_done, run, turn_on;

  assign trip_eff = trip_s & (blank_cnt == '0);
  assign cause    = trip_eff | lsuv_s;
  assign clr_done = (clr_cnt == CW'(CLR_CYC));
  assign fault_n  = ~cause & clr_done;
  assign run      = fault_n & en_f;
  assign arm_now  = ~hsuv_s & (arm | ~hcmd_q);
  assign hi_gate  = hi_cmd & arm_now & {N_PH{run}};
  assign lo_gate  = lo_cmd & {N_PH{run}};
  assign turn_on  = |({hi_gate, lo_gate} & ~{hi_q, lo_q});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clr_cnt   <= '0;
      blank_cnt <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      hcmd_q    <= '0;
      arm       <= '1;
    end else begin
      if (cause)
        clr_cnt <= '0;
      else if (!clr_done)
        clr_cnt <= clr_cnt + 1'b1;

      if (turn_on)
        blank_cnt <= BW'(BLANK_CYC);
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;

      hi_q   <= hi_gate;
      lo_q   <= lo_gate;
      hcmd_q <= hi_cmd;
      arm    <= arm_now;
    end
endmodule

// File: rtl/gdrv_fault_sup_chk.sv
module gdrv_fault_sup_chk #(
  parameter int N_PH    = 3,
  parameter int CLR_CYC = 1000,
  parameter int CW      = 10,
  parameter int BW      = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_PH-1:0] hi_cmd,
  input logic [N_PH-1:0] lo_cmd,
  input logic [N_PH-1:0] hi_gate,
  input logic [N_PH-1:0] lo_gate,
  input logic            fault_n,
  input logic            trip_s,
  input logic            lsuv_s,
  input logic [N_PH-1:0] hsuv_s,
  input logic            en_f,
  input logic [BW-1:0]   blank_cnt,
  input logic [CW-1:0]   clr_cnt
);
  logic seen_rst = 1'b0;

  always @(posedge clk) begin
    if (!rst_n && seen_rst)
      p_reset_off_r1: assert (!fault_n && hi_gate == '0 && lo_gate == '0);
    seen_rst <= !rst_n;
  end

  p_trip_kill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_s && blank_cnt == '0) |-> (!fault_n && hi_gate == '0 && lo_gate == '0));

  p_release_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (!$past(lsuv_s) && !$past(trip_s && blank_cnt == '0)));

  p_lsuv_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lsuv_s |-> (!fault_n && hi_gate == '0 && lo_gate == '0));

  p_hsuv_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate & hsuv_s) == '0);

  p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_f |-> (hi_gate == '0 && lo_gate == '0));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt <= CW'(CLR_CYC));

  p_fault_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (hi_gate == '0 && lo_gate == '0));

  p_gate_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_gate & ~hi_cmd) | (lo_gate & ~lo_cmd)) == '0);
endmodule

bind gdrv_fault_sup gdrv_fault_sup_chk #(
  .N_PH(N_PH), .CLR_CYC(CLR_CYC), .CW(CW), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
  .hi_gate(hi_gate), .lo_gate(lo_gate), .fault_n(fault_n),
  .trip_s(trip_s), .lsuv_s(lsuv_s), .hsuv_s(hsuv_s), .en_f(en_f),
  .blank_cnt(blank_cnt), .clr_cnt(clr_cnt)
);

// File: tb/gdrv_fault_sup_bench.sv
`timescale 1ns/1ps
module gdrv_fault_sup_bench;
  localparam int CLR = 20;
  localparam int BLK = 6;
  localparam int EF  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hi_cmd = 3'b001, lo_cmd = 3'b010, hsuv_in = 3'b000;
  logic       trip_in = 1'b0, lsuv_in = 1'b0, en_in = 1'b1;
  logic [2:0] hi_gate, lo_gate;
  logic       fault_n;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  gdrv_fault_sup #(.N_PH(3), .BLANK_CYC(BLK), .EN_FILT_CYC(EF), .CLR_CYC(CLR))
    u_gdrv_fault_sup (
      .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
      .trip_in(trip_in), .lsuv_in(lsuv_in), .hsuv_in(hsuv_in), .en_in(en_in),
      .hi_gate(hi_gate), .lo_gate(lo_gate), .fault_n(fault_n));

  // [15:13] hi_cmd [12:10] lo_cmd [9] en [8:6] hsuv [5:3] exp hi [2:0] exp lo
  localparam logic [15:0] VEC [8] = '{
    {3'b001, 3'b010, 1'b1, 3'b000, 3'b001, 3'b010},
    {3'b101, 3'b010, 1'b1, 3'b000, 3'b101, 3'b010},
    {3'b101, 3'b010, 1'b1, 3'b100, 3'b001, 3'b010},
    {3'b101, 3'b010, 1'b1, 3'b000, 3'b001, 3'b010},
    {3'b001, 3'b010, 1'b1, 3'b000, 3'b001, 3'b010},
    {3'b101, 3'b010, 1'b1, 3'b000, 3'b101, 3'b010},
    {3'b101, 3'b110, 1'b0, 3'b000, 3'b000, 3'b000},
    {3'b101, 3'b110, 1'b1, 3'b000, 3'b101, 3'b110}
  };

  localparam logic [6:0] OFF = 7'b0_000_000;
  localparam logic [6:0] ON  = 7'b1_101_110;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {fault_n, hi_gate, lo_gate};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 run: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", OFF);
    rst_n = 1'b1;
    cyc(CLR - 1);
    chk("R1 held through clear interval", OFF);
    cyc(1);
    chk("R1 released after clear interval", 7'b1_001_010);

    for (int i = 0; i < 8; i++) begin
      hi_cmd  = VEC[i][15:13];
      lo_cmd  = VEC[i][12:10];
      en_in   = VEC[i][9];
      hsuv_in = VEC[i][8:6];
      cyc(8);
      chk($sformatf("R5 R6 R7 table step %0d", i), {1'b1, VEC[i][5:0]});
    end

    cyc(3 * CLR);
    chk("R10 fault stays released", ON);

    trip_in = 1'b1;
    cyc(1);
    chk("R2 not yet synchronized", ON);
    cyc(1);
    chk("R2 trip forces off", OFF);
    cyc(4);
    trip_in = 1'b0;
    cyc(2 + CLR - 1);
    chk("R3 held one edge before clear", OFF);
    cyc(1);
    chk("R3 released at clear", ON);

    trip_in = 1'b1;
    cyc(4);
    chk("R9 trip ignored in blanking", ON);
    cyc(5);
    chk("R9 trip acts after blanking", OFF);
    trip_in = 1'b0;
    cyc(2 + CLR);
    chk("R3 second release", ON);

    lsuv_in = 1'b1;
    cyc(3);
    chk("R4 low-side uv forces fault", OFF);
    cyc(5);
    lsuv_in = 1'b0;
    cyc(2 + CLR - 1);
    chk("R4 held through clear", OFF);
    cyc(1);
    chk("R4 not latched", ON);

    en_in = 1'b0;
    cyc(8);
    chk("R7 enable low, fault untouched", 7'b1_000_000);
    en_in = 1'b1;
    cyc(8);
    chk("R7 enable resumes", ON);

    en_in = 1'b0;
    cyc(2);
    en_in = 1'b1;
    cyc(2);
    chk("R8 short low pulse rejected", ON);
    cyc(6);
    chk("R8 still on after pulse", ON);

    en_in = 1'b0;
    trip_in = 1'b1;
    cyc(10);
    chk("R11 fault low with enable low", OFF);
    en_in = 1'b1;
    cyc(10);
    chk("R11 fault overrides enable", OFF);
    trip_in = 1'b0;
    cyc(2 + CLR);
    chk("R11 recovery", ON);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule